// File: doc/BRIEF.md
# Dual-Standard Video Capture Timing Generator

This block produces the digital strobes that let an external converter sample a sensor's composite video in lock with its pixels. It runs on the pixel clock and walks a pixel counter and a line counter through either a 625-line or a 525-line raster. From that position it derives a pixel qualifier, a visible-line marker, a field marker, the odd/even field flag and an enable for the analog video driver.

The driver enable can be limited to the sync region or to one quarter of the picture, so several sensors can share one monitor. A 3-line dark band runs between the top and bottom halves of the picture, and a 2-pixel gap runs between the left and right halves. A falling edge on the external sync input restarts the raster. The pixel counter then takes a fixed base plus a programmable offset. The line standard is sampled only at reset and at that sync edge.

All outputs are registered. During reset every output is held low. From then on, each output shows the counter position one clock earlier.

Top module: `vidcap_timing`

## Requirements
- R1: While `rst` is high, all five outputs are 0, the raster goes to pixel 0, line 0 of an even field, and `std_sel` is latched as the standard. After reset, every output shows the decode of the counter position one clock earlier, so the first clock after reset shows pixel 0, line 0.
- R2: A line lasts 472 clocks in 625 mode (`std_sel`=1) and 381 clocks in 525 mode. Fields alternate between 313 lines (even field, `odd_field`=0) and 312 lines (odd field, `odd_field`=1) in 625 mode, and between 263 and 262 lines in 525 mode. The first field after reset is even.
- R3: With `pv_mode`=01, `pix_valid` is 1 on visible pixels of visible lines. Visible pixels are pixel 78..461 in 625 mode and pixel 53..372 in 525 mode. Visible lines are line 11..297 in 625 mode and line 12..254 in 525 mode.
- R4: `line_start` is 1 for the first 34 clocks (625 mode) or 28 clocks (525 mode) of each visible line, and 0 everywhere else.
- R5: `field_start` is 1 for the first 57 clocks (625 mode) or 45 clocks (525 mode) of line 0, and 0 everywhere else.
- R6: For `oe_code` 000 `video_oe` is always 1. For 001 it is always 0. For 010 it is 1 only in the sync region. For 011 it is 1 in the sync region or in quarter 1. The sync region is pixels below 35 (625 mode) or 29 (525 mode), plus all of lines 0..2.
- R7: For `oe_code` values 100, 101, 110 and 111, `video_oe` is 1 only in quarter 1, 2, 3 or 4 respectively. The quarters are top-left, top-right, bottom-left and bottom-right.
  - The left half covers pixels porch+1 to porch+half, where half is 190 (625 mode) or 158 (525 mode).
  - The right half starts 2 pixels after the left half ends and has the same width.
  - The top half covers lines first to first+142 (625 mode) or first+120 (525 mode), end exclusive.
  - The bottom half starts 3 lines after the top half ends and has the same height.
- R8: With `pv_mode`=10, `pix_valid` marks a 256x256 window in 625 mode: pixel 142..397 on line 26..281. In 525 mode `pix_valid` stays 0 for this code.
- R9: With `pv_mode`=00, `pix_valid` is 0. With `pv_mode`=11, `pix_valid` is 1 on visible lines at pixels outside the visible pixel range.
- R10: When `pv_free`=1, `pix_valid` is 1 whatever the value of `pv_mode`.
- R11: A 1-to-0 transition of `ext_sync` sampled at a clock edge loads the pixel counter with 2 + `sync_ofs`, sets the line counter to 0 and starts an even field. Rising edges have no effect.
- R12: A change of `std_sel` takes effect only at reset or at a sync fall. While neither occurs, the line and field lengths keep the standard already in use.
- R13: When a sync fall arrives on the last clock of a line, the sync reload wins over the line wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| std_sel | input | 1 | Line standard request: 1 selects 625-line, 0 selects 525-line |
| ext_sync | input | 1 | External sync; a falling edge restarts the raster |
| sync_ofs | input | OFS_W | Offset added to the pixel-counter base on a sync reload |
| oe_code | input | 3 | Selects the regions in which the video driver is enabled |
| pv_mode | input | 2 | Selects the pixel-valid pattern |
| pv_free | input | 1 | Forces pixel-valid high |
| pix_valid | output | 1 | Pixel qualifier |
| line_start | output | 1 | Visible-line start pulse |
| field_start | output | 1 | Field start pulse |
| odd_field | output | 1 | 1 during odd fields |
| video_oe | output | 1 | Analog video driver enable |

## Verification
A sync reload and the end-of-line wrap can meet in the same clock: the counter is at its last pixel when the sync input falls. The bench uses its own raster model to find that clock and then drops `ext_sync` so that the fall lands exactly there. The result is judged in two ways. The following `field_start` pulse must last 57 − (2 + 10) = 45 clocks, which shows the reload value, not 0, was taken. The model, which gives the reload priority, must also match every output on every clock around the event.

// File: rtl/vct_pkg.sv
package vct_pkg;
  localparam int CW           = 9;
  localparam int VSYNC_LINES  = 3;
  localparam int HALF_GAP_PIX = 2;
  localparam int BAND_LINES   = 3;
  localparam int WIN_SIZE     = 256;
  localparam int WIN_H_OFS    = 64;
  localparam int WIN_V_OFS    = 15;

  typedef struct packed {
    logic [CW-1:0] porch;
    logic [CW-1:0] vis_pix;
    logic [CW-1:0] lst_len;
    logic [CW-1:0] fst_len;
    logic [CW-1:0] hsync_len;
    logic [CW-1:0] half_pix;
    logic [CW-1:0] first_line;
    logic [CW-1:0] vis_lines;
    logic [CW-1:0] half_lines;
  } disp_t;

  typedef enum logic [2:0] {
    OE_ALL, OE_NONE, OE_SYNC, OE_SYNC_Q1, OE_Q1, OE_Q2, OE_Q3, OE_Q4
  } oe_sel_e;

  typedef enum logic [1:0] {PV_OFF, PV_IMAGE, PV_WINDOW, PV_INTERLINE} pv_sel_e;

  function automatic logic [CW-1:0] line_len_of(input logic is625);
    return is625 ? CW'(472) : CW'(381);
  endfunction

  function automatic logic [CW-1:0] field_len_of(input logic is625, input logic odd);
    if (is625) return odd ? CW'(312) : CW'(313);
    return odd ? CW'(262) : CW'(263);
  endfunction

  function automatic disp_t disp_of(input logic is625);
    disp_t d;
    if (is625) begin
      d.porch = CW'(78);  d.vis_pix = CW'(384); d.lst_len = CW'(34);
      d.fst_len = CW'(57); d.hsync_len = CW'(35); d.half_pix = CW'(190);
      d.first_line = CW'(11); d.vis_lines = CW'(287); d.half_lines = CW'(142);
    end else begin
      d.porch = CW'(53);  d.vis_pix = CW'(320); d.lst_len = CW'(28);
      d.fst_len = CW'(45); d.hsync_len = CW'(29); d.half_pix = CW'(158);
      d.first_line = CW'(12); d.vis_lines = CW'(243); d.half_lines = CW'(120);
    end
    return d;
  endfunction
endpackage

// File: rtl/vct_counters.sv
module vct_counters
  import vct_pkg::*;
#(
  parameter int OFS_W      = 6,
  parameter int HLOAD_BASE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             std_sel,
  input  logic             ext_sync,
  input  logic [OFS_W-1:0] sync_ofs,
  output logic [CW-1:0]    hcnt_q,
  output logic [CW-1:0]    vcnt_q,
  output logic             odd_q,
  output logic             std_q
);
  logic          sync_prev_q;
  logic          sync_fall;
  logic [CW-1:0] line_len;
  logic [CW-1:0] field_len;
  logic [CW-1:0] load_val;

  assign sync_fall = sync_prev_q & ~ext_sync;
  assign line_len  = line_len_of(std_q);
  assign field_len = field_len_of(std_q, odd_q);
  assign load_val  = CW'(HLOAD_BASE) + CW'(sync_ofs);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt_q      <= '0;
      vcnt_q      <= '0;
      odd_q       <= 1'b0;
      std_q       <= std_sel;
      sync_prev_q <= 1'b1;
    end else begin
      sync_prev_q <= ext_sync;
      if (sync_fall) begin
        hcnt_q <= load_val;
        vcnt_q <= '0;
        odd_q  <= 1'b0;
        std_q  <= std_sel;
      end else if (hcnt_q == line_len - CW'(1)) begin
        hcnt_q <= '0;
        if (vcnt_q == field_len - CW'(1)) begin
          vcnt_q <= '0;
          odd_q  <= ~odd_q;
        end else begin
          vcnt_q <= vcnt_q + CW'(1);
        end
      end else begin
        hcnt_q <= hcnt_q + CW'(1);
      end
    end
  end

  // R11
  sync_load_chk: assert property (@(posedge clk) disable iff (rst)
    sync_fall |=> (hcnt_q == $past(load_val)) && (vcnt_q == '0) && !odd_q);

  // R13
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (hcnt_q == line_len - CW'(1)) && !sync_fall |=> hcnt_q == '0);

  // R2
  parity_at_top_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(odd_q) |-> (vcnt_q == '0));

  // R12
  std_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sync_fall |=> $stable(std_q));
endmodule

// File: rtl/vct_decode.sv
module vct_decode
  import vct_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] hcnt,
  input  logic [CW-1:0] vcnt,
  input  logic          odd,
  input  logic          std_q,
  input  logic [2:0]    oe_code,
  input  logic [1:0]    pv_mode,
  input  logic          pv_free,
  output logic          pix_valid,
  output logic          line_start,
  output logic          field_start,
  output logic          odd_field,
  output logic          video_oe
);
  disp_t tm;
  assign tm = disp_of(std_q);

  logic [CW-1:0] h_end, ql_beg, ql_end, qr_beg, qr_end;
  logic [CW-1:0] v_end, vt_end, vb_beg, vb_end;
  logic [CW-1:0] wh_beg, wh_end, wv_beg, wv_end;

  assign h_end  = tm.porch + tm.vis_pix;
  assign ql_beg = tm.porch + CW'(1);
  assign ql_end = ql_beg + tm.half_pix;
  assign qr_beg = ql_end + CW'(HALF_GAP_PIX);
  assign qr_end = qr_beg + tm.half_pix;
  assign v_end  = tm.first_line + tm.vis_lines;
  assign vt_end = tm.first_line + tm.half_lines;
  assign vb_beg = vt_end + CW'(BAND_LINES);
  assign vb_end = vb_beg + tm.half_lines;
  assign wh_beg = tm.porch + CW'(WIN_H_OFS);
  assign wh_end = wh_beg + CW'(WIN_SIZE);
  assign wv_beg = tm.first_line + CW'(WIN_V_OFS);
  assign wv_end = wv_beg + CW'(WIN_SIZE);

  logic h_in, v_in, in_l, in_r, in_t, in_b, in_win, sync_rg;
  logic [3:0] quad;

  assign h_in    = (hcnt >= tm.porch) && (hcnt < h_end);
  assign v_in    = (vcnt >= tm.first_line) && (vcnt < v_end);
  assign in_l    = (hcnt >= ql_beg) && (hcnt < ql_end);
  assign in_r    = (hcnt >= qr_beg) && (hcnt < qr_end);
  assign in_t    = (vcnt >= tm.first_line) && (vcnt < vt_end);
  assign in_b    = (vcnt >= vb_beg) && (vcnt < vb_end);
  assign in_win  = std_q && (hcnt >= wh_beg) && (hcnt < wh_end) &&
                   (vcnt >= wv_beg) && (vcnt < wv_end);
  assign sync_rg = (hcnt < tm.hsync_len) || (vcnt < CW'(VSYNC_LINES));

  for (genvar gi = 0; gi < 4; gi++) begin : g_quad
    localparam bit RIGHT  = gi[0];
    localparam bit BOTTOM = gi[1];
    assign quad[gi] = (RIGHT ? in_r : in_l) & (BOTTOM ? in_b : in_t);
  end

  logic oe_c, pv_c, ls_c, fs_c;

  always_comb begin
    case (oe_sel_e'(oe_code))
      OE_ALL:     oe_c = 1'b1;
      OE_NONE:    oe_c = 1'b0;
      OE_SYNC:    oe_c = sync_rg;
      OE_SYNC_Q1: oe_c = sync_rg | quad[0];
      OE_Q1:      oe_c = quad[0];
      OE_Q2:      oe_c = quad[1];
      OE_Q3:      oe_c = quad[2];
      default:    oe_c = quad[3];
    endcase
  end

  always_comb begin
    if (pv_free) pv_c = 1'b1;
    else begin
      case (pv_sel_e'(pv_mode))
        PV_OFF:    pv_c = 1'b0;
        PV_IMAGE:  pv_c = h_in & v_in;
        PV_WINDOW: pv_c = in_win;
        default:   pv_c = v_in & ~h_in;
      endcase
    end
  end

  assign ls_c = v_in && (hcnt < tm.lst_len);
  assign fs_c = (vcnt == '0) && (hcnt < tm.fst_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid   <= 1'b0;
      line_start  <= 1'b0;
      field_start <= 1'b0;
      odd_field   <= 1'b0;
      video_oe    <= 1'b0;
    end else begin
      pix_valid   <= pv_c;
      line_start  <= ls_c;
      field_start <= fs_c;
      odd_field   <= odd;
      video_oe    <= oe_c;
    end
  end

  // R7
  quad_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(quad));

  // R4
  ls_blank_chk: assert property (@(posedge clk) disable iff (rst)
    ls_c |-> !h_in);

  // R8
  win_inside_chk: assert property (@(posedge clk) disable iff (rst)
    in_win |-> (h_in && v_in));
endmodule

// File: rtl/vidcap_timing.sv
module vidcap_timing
  import vct_pkg::*;
#(
  parameter int OFS_W      = 6,
  parameter int HLOAD_BASE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             std_sel,
  input  logic             ext_sync,
  input  logic [OFS_W-1:0] sync_ofs,
  input  logic [2:0]       oe_code,
  input  logic [1:0]       pv_mode,
  input  logic             pv_free,
  output logic             pix_valid,
  output logic             line_start,
  output logic             field_start,
  output logic             odd_field,
  output logic             video_oe
);
  logic [CW-1:0] hcnt, vcnt;
  logic          odd, std_q;

  vct_counters #(.OFS_W(OFS_W), .HLOAD_BASE(HLOAD_BASE)) u_cnt (
    .clk(clk), .rst(rst), .std_sel(std_sel), .ext_sync(ext_sync),
    .sync_ofs(sync_ofs), .hcnt_q(hcnt), .vcnt_q(vcnt), .odd_q(odd), .std_q(std_q)
  );

  vct_decode u_dec (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt), .odd(odd), .std_q(std_q),
    .oe_code(oe_code), .pv_mode(pv_mode), .pv_free(pv_free),
    .pix_valid(pix_valid), .line_start(line_start), .field_start(field_start),
    .odd_field(odd_field), .video_oe(video_oe)
  );

  // R6
  oe_none_chk: assert property (@(posedge clk) disable iff (rst)
    (oe_code == 3'b001) |=> !video_oe);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !(pix_valid | line_start | field_start | odd_field | video_oe));
endmodule

// File: tb/vidcap_timing_bench.sv
module vidcap_timing_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic std_sel = 1'b0;
  logic ext_sync = 1'b1;
  logic [5:0] sync_ofs = 6'd3;
  logic [2:0] oe_code = 3'd0;
  logic [1:0] pv_mode = 2'd1;
  logic pv_free = 1'b0;
  logic pix_valid, line_start, field_start, odd_field, video_oe;

  vidcap_timing u_vidcap_timing (
    .clk(clk), .rst(rst), .std_sel(std_sel), .ext_sync(ext_sync), .sync_ofs(sync_ofs),
    .oe_code(oe_code), .pv_mode(pv_mode), .pv_free(pv_free),
    .pix_valid(pix_valid), .line_start(line_start), .field_start(field_start),
    .odd_field(odd_field), .video_oe(video_oe)
  );

  always #5 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int got, int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
    end
  endtask

  typedef struct {
    bit pv; bit ls; bit fs; bit od; bit oe;
    string tpv; string toe; string tgen;
  } exp_t;
  exp_t exp_q[$];

  // Raster model, built from the requirements
  int mh = 0, mv = 0;
  bit modd = 0, mstd = 0, mprev = 1;

  function automatic exp_t model_out(int h, int v, bit od, bit s,
                                     logic [2:0] oc, logic [1:0] pm, bit fr);
    exp_t e;
    int porch, vis, lst, fst, hs, half, first, vl, hl;
    bit hin, vin, il, ir, it, ib, sy, win;
    if (s) begin
      porch = 78; vis = 384; lst = 34; fst = 57; hs = 35; half = 190;
      first = 11; vl = 287; hl = 142;
    end else begin
      porch = 53; vis = 320; lst = 28; fst = 45; hs = 29; half = 158;
      first = 12; vl = 243; hl = 120;
    end
    hin = (h >= porch) && (h < porch + vis);
    vin = (v >= first) && (v < first + vl);
    il  = (h >= porch + 1) && (h < porch + 1 + half);
    ir  = (h >= porch + 3 + half) && (h < porch + 3 + 2 * half);
    it  = (v >= first) && (v < first + hl);
    ib  = (v >= first + hl + 3) && (v < first + 2 * hl + 3);
    sy  = (h < hs) || (v < 3);
    win = s && (h >= porch + 64) && (h < porch + 320) && (v >= first + 15) && (v < first + 271);
    case (oc)
      3'd0: e.oe = 1;
      3'd1: e.oe = 0;
      3'd2: e.oe = sy;
      3'd3: e.oe = sy | (il & it);
      3'd4: e.oe = il & it;
      3'd5: e.oe = ir & it;
      3'd6: e.oe = il & ib;
      default: e.oe = ir & ib;
    endcase
    if (fr) e.pv = 1;
    else case (pm)
      2'd0: e.pv = 0;
      2'd1: e.pv = hin & vin;
      2'd2: e.pv = win;
      default: e.pv = vin & !hin;
    endcase
    e.ls = vin && (h < lst);
    e.fs = (v == 0) && (h < fst);
    e.od = od;
    e.tpv  = fr ? "R10" : (pm == 2'd2) ? "R8" : (pm == 2'd1) ? "R3" : "R9";
    e.toe  = (oc < 3'd4) ? "R6" : "R7";
    e.tgen = "";
    return e;
  endfunction

  // Directed statistics
  int cyc = 0;
  int fs_rise = -1, fs_period = 0, fs_run = 0, fs_run_last = 0;
  int ls_rise = -1, ls_period = 0;
  bit fs_last = 0, ls_last = 0;

  always @(negedge clk) begin
    exp_t e, got;
    int ll, fl;
    bit fall;
    if (!done) begin
      // driver side: expected outputs for the edge that just passed
      if (rst) begin
        e = '{pv:0, ls:0, fs:0, od:0, oe:0, tpv:"R1", toe:"R1", tgen:"R1"};
      end else begin
        e = model_out(mh, mv, modd, mstd, oe_code, pv_mode, pv_free);
      end
      exp_q.push_back(e);
      // advance the model to the counter state after that edge
      if (rst) begin
        mh = 0; mv = 0; modd = 0; mstd = std_sel; mprev = 1;
      end else begin
        fall  = mprev && !ext_sync;
        mprev = ext_sync;
        ll = mstd ? 472 : 381;
        fl = mstd ? (modd ? 312 : 313) : (modd ? 262 : 263);
        if (fall) begin
          mh = 2 + int'(sync_ofs); mv = 0; modd = 0; mstd = std_sel;
        end else if (mh == ll - 1) begin
          mh = 0;
          if (mv == fl - 1) begin mv = 0; modd = !modd; end
          else mv = mv + 1;
        end else mh = mh + 1;
      end
      // monitor side
      got = exp_q.pop_front();
      chk(got.tpv,  "pix_valid",   pix_valid,   got.pv);
      chk(got.tgen == "" ? "R4" : got.tgen, "line_start",  line_start,  got.ls);
      chk(got.tgen == "" ? "R5" : got.tgen, "field_start", field_start, got.fs);
      chk(got.tgen == "" ? "R2" : got.tgen, "odd_field",   odd_field,   got.od);
      chk(got.toe,  "video_oe",    video_oe,    got.oe);
      // statistics at the ports
      cyc++;
      if (field_start && !fs_last) begin
        if (fs_rise >= 0) fs_period = cyc - fs_rise;
        fs_rise = cyc;
      end
      if (field_start) fs_run++;
      else if (fs_last) begin fs_run_last = fs_run; fs_run = 0; end
      if (line_start && !ls_last) begin
        if (ls_rise >= 0) ls_period = cyc - ls_rise;
        ls_rise = cyc;
      end
      fs_last = field_start;
      ls_last = line_start;
    end
  end

  logic [15:0] lfsr = 16'hACE1;
  int tick_n = 0;

  task automatic tick();
    @(negedge clk);
    #1;
    tick_n++;
    if (tick_n % 97 == 0) begin
      lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      oe_code = lfsr[2:0];
      pv_mode = lfsr[4:3];
      pv_free = (lfsr[7:5] == 3'd0);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nerr++;
    $display("FAIL R1 watchdog got=timeout exp=completion");
    finish_run();
  end

  initial begin
    // R1: reset in 525 mode
    repeat (4) tick();
    chk("R1", "reset outputs", {pix_valid, line_start, field_start, odd_field, video_oe}, 0);
    rst = 1'b0;
    tick();
    chk("R1", "first field_start after reset", field_start, 1);
    chk("R1", "odd_field after reset", odd_field, 0);
    repeat (1000) tick();
    // R12: request 625 mode mid-field; must be ignored
    std_sel = 1'b1;
    repeat (5000) tick();
    chk("R12", "line period unchanged without sync", ls_period, 381);
    repeat (95500) tick();
    chk("R2", "first field length in clocks", fs_period, 263 * 381);
    chk("R2", "odd flag in second field", odd_field, 1);
    chk("R5", "field_start width 525", fs_run_last, 45);
    // R11: sync fall mid-line, offset 3
    sync_ofs = 6'd3;
    ext_sync = 1'b0;
    repeat (4) tick();
    ext_sync = 1'b1;
    repeat (200) tick();
    chk("R11", "field_start width after reload", fs_run_last, 57 - 5);
    chk("R11", "even field after reload", odd_field, 0);
    repeat (2000) tick();
    // R13: sync fall on the last clock of a line
    while (mh != 471) tick();
    sync_ofs = 6'd10;
    ext_sync = 1'b0;
    repeat (4) tick();
    ext_sync = 1'b1;
    repeat (200) tick();
    chk("R13", "field_start width after colliding reload", fs_run_last, 57 - 12);
    repeat (78200) tick();
    chk("R12", "625 line period after sync", ls_period, 472);
    chk("R2", "odd flag still even", odd_field, 0);
    finish_run();
  end
endmodule